// File: doc/BRIEF.md
# Nine-bit capable asynchronous serial port

This block is a full-duplex asynchronous serial port for a small microcontroller-style register bus. It has two register addresses. The data address works in two directions. A write to it loads a byte and starts a transmit frame at once. A read from it returns the byte most recently received. The control address holds the mode selections, the transmit ninth bit, the captured receive ninth bit and three status flags.

Bit timing comes from an external baud source. That source pulses `tick16` sixteen times per bit period. The transmitter and the receiver each count these ticks on their own, so a frame can go out on `txd` while another frame arrives on `rxd`.

In plain mode a frame is a start bit, eight data bits sent least significant bit first, and a stop bit. In nine-bit mode a software-supplied ninth bit goes between the data and the stop bit. Either mode can add a second stop bit.

Control register layout (address 1):

| Bit | Meaning |
| --- | --- |
| 0 | transmit-done flag |
| 1 | receive-done flag |
| 2 | received ninth bit, read-only |
| 3 | ninth bit to transmit |
| 4 | nine-bit mode enable |
| 5 | two-stop-bit enable |
| 6 | framing-error flag |
| 7 | reads 0 |

Top module: `sio9_port`

## Requirements
- R1: When the transmitter is idle, a write to address 0 starts a frame. The frame is a low start bit, then `wdata` least significant bit first. Each bit lasts 16 `tick16` pulses.
- R2: A read with `rd` high at address 0 returns the last received byte. `rdata` is 0 whenever `rd` is low.
- R3: With control bit 4 clear, the frame carries eight data bits and then a high stop bit. With control bit 4 set, control bit 3 is sent as a ninth bit after the data and before the stop bit.
- R4: In nine-bit mode the received ninth bit is stored in control bit 2. In plain mode a received frame stores 0 there.
- R5: Control bit 5 adds a second high stop bit. Transmit-done (control bit 0) rises at the end of the last stop bit.
- R6: Transmit and receive run at the same time and do not disturb each other.
- R7: The receiver samples each bit at its middle. It ignores a falling edge when the line is high again at the middle of the start bit.
- R8: A stop bit sampled low sets framing-error (control bit 6). The received byte is still stored.
- R9: `txd` stays high whenever no frame is being sent. A write to address 0 during a frame does not change that frame.
- R10: Receive-done (control bit 1) is set when a frame is received. A control write clears any flag (bits 0, 1, 6) whose written bit is 0 and keeps any flag whose written bit is 1. Writes to bit 2 have no effect.
- R11: After reset the control register reads 0 and `txd` is high.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick16 | input | 1 | one pulse per sixteenth of a bit period |
| addr | input | 1 | 0 selects the data buffer, 1 selects the control register |
| wr | input | 1 | write strobe |
| rd | input | 1 | read strobe |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, 0 when `rd` is low |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |

## Verification
The transmitter drives the receiver in loopback with every combination of frame options. The options are plain or nine-bit mode, the ninth bit 0 or 1, and one or two stop bits. The data patterns are 0x00, 0xFF, single bits at either end, and mixed bytes, so a reversed bit order or a misplaced ninth bit is caught.

The bench samples each transmitted bit at its middle and times the done flag against the expected frame length. A wrong bit count or a missing second stop bit therefore shows up.

Bench-driven frames test further cases. One frame is received while a different byte is sent, to show the two directions stay independent. Another has a low stop bit, to raise the framing error. A short low pulse must be rejected, and a valid frame right after it must still be received. A second write in the middle of a frame must leave that frame intact.

// File: rtl/sio9_port.sv
module sio9_port #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd
);
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
  localparam logic [TW-1:0] TMID  = TW'(OVS / 2 - 1);

  logic nine, two, tx9, tx_done, rx_done, rx9, fe;
  logic tx_busy;
  logic [11:0] tx_sh;
  logic [3:0] tx_n;
  logic [TW-1:0] tx_tc;
  logic rx_busy, rx_meta, rx_s, rx_p, rx9_sh;
  logic [3:0] rx_idx;
  logic [TW-1:0] rx_tc;
  logic [7:0] rx_sh, rx_buf;

  wire wr_data = wr && !addr;
  wire wr_ctl  = wr && addr;
  wire tx_end  = tx_busy && tick16 && tx_tc == TLAST && tx_n == 4'd1;
  wire rx_mid  = rx_busy && tick16 && rx_tc == TMID;
  wire rx_stop = rx_idx == (nine ? 4'd10 : 4'd9);
  wire rx_fin  = rx_mid && rx_stop;
  wire [7:0] ctl = {1'b0, fe, two, nine, tx9, rx9, rx_done, tx_done};

  assign txd   = !tx_busy || tx_sh[0];
  assign rdata = rd ? (addr ? ctl : rx_buf) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_n    <= '0;
      tx_tc   <= '0;
    end else if (!tx_busy) begin
      if (wr_data) begin
        tx_busy <= 1'b1;
        tx_sh   <= nine ? {2'b11, tx9, wdata, 1'b0} : {3'b111, wdata, 1'b0};
        tx_n    <= 4'd10 + {3'b000, nine} + {3'b000, two};
        tx_tc   <= '0;
      end
    end else if (tick16) begin
      tx_tc <= (tx_tc == TLAST) ? '0 : tx_tc + 1'b1;
      if (tx_tc == TLAST) begin
        if (tx_n == 4'd1) tx_busy <= 1'b0;
        else begin
          tx_sh <= {1'b1, tx_sh[11:1]};
          tx_n  <= tx_n - 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
      rx_p    <= 1'b1;
      rx_busy <= 1'b0;
      rx_idx  <= '0;
      rx_tc   <= '0;
      rx_sh   <= '0;
      rx9_sh  <= 1'b0;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
      rx_p    <= rx_s;
      if (!rx_busy) begin
        if (rx_p && !rx_s) begin
          rx_busy <= 1'b1;
          rx_idx  <= '0;
          rx_tc   <= '0;
        end
      end else if (tick16) begin
        rx_tc <= (rx_tc == TLAST) ? '0 : rx_tc + 1'b1;
        if (rx_tc == TMID) begin
          rx_idx <= rx_idx + 4'd1;
          if ((rx_idx == 4'd0 && rx_s) || rx_stop) rx_busy <= 1'b0;
          else if (rx_idx >= 4'd1 && rx_idx <= 4'd8) rx_sh <= {rx_s, rx_sh[7:1]};
          else if (rx_idx == 4'd9) rx9_sh <= rx_s;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {nine, two, tx9, tx_done, rx_done, rx9, fe} <= '0;
      rx_buf <= '0;
    end else begin
      if (wr_ctl) begin
        tx9     <= wdata[3];
        nine    <= wdata[4];
        two     <= wdata[5];
        tx_done <= tx_done & wdata[0];
        rx_done <= rx_done & wdata[1];
        fe      <= fe & wdata[6];
      end
      if (tx_end) tx_done <= 1'b1;
      if (rx_fin) begin
        rx_buf  <= rx_sh;
        rx9     <= nine & rx9_sh;
        fe      <= !rx_s;
        rx_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio9_port_chk.sv
module sio9_port_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic txd,
  input logic tx_busy,
  input logic rx_busy,
  input logic tx_done,
  input logic rx_done
);
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  a_r1_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick16) |=> $stable(txd));
  a_r5_txdone_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(tx_busy));
  a_r10_rxdone_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $fell(rx_busy));
endmodule

bind sio9_port sio9_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .txd(txd),
  .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_done(tx_done), .rx_done(rx_done)
);

// File: tb/tb_sio9_port.sv
module tb_sio9_port;
  logic clk = 1'b0, rst_n = 1'b0, tick16, addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic rxd, txd, loop = 1'b0, drv = 1'b1;
  logic [1:0] divc = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) divc <= divc + 2'd1;
  assign tick16 = (divc == 2'd3);
  assign rxd = loop ? txd : drv;

  sio9_port dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .addr(addr), .wr(wr),
    .rd(rd), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd));

  // {two_stop, nine_mode, ninth_bit, data}
  localparam logic [10:0] VEC [6] = '{
    {3'b000, 8'h53}, {3'b011, 8'hC6}, {3'b100, 8'hFF},
    {3'b110, 8'h01}, {3'b010, 8'h80}, {3'b111, 8'h00}};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    rd = 1'b0;
  endtask

  task automatic cap(input int n, output logic [11:0] b);
    b = '1;
    repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      b[i] = txd;
      if (i < n - 1) repeat (64) @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9, input logic stopv);
    drv = 1'b0; repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin drv = d[i]; repeat (64) @(negedge clk); end
    if (nine) begin drv = b9; repeat (64) @(negedge clk); end
    drv = stopv; repeat (64) @(negedge clk);
    drv = 1'b1; repeat (64) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [11:0] b, e;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(1'b1, v); chk("R11 ctrl reset", v, 8'h00);
    chk("R11 txd reset", txd, 1'b1);
    addr = 1'b1; #1 chk("R2 rdata without rd", rdata, 8'h00);

    loop = 1'b1;
    foreach (VEC[k]) begin
      logic two, nine, b9;
      logic [7:0] d;
      {two, nine, b9, d} = VEC[k];
      n = 10 + int'(nine) + int'(two);
      e = nine ? {2'b11, b9, d, 1'b0} : {3'b111, d, 1'b0};
      reg_wr(1'b1, {2'b00, two, nine, b9, 3'b000});
      reg_wr(1'b0, d);
      cap(n, b);
      chk("R1 R3 R5 frame bits", b, e);
      repeat (24) @(negedge clk);
      reg_rd(1'b1, v); chk("R5 done not early", v[0], 1'b0);
      repeat (16) @(negedge clk);
      reg_rd(1'b1, v); chk("R5 done at frame end", v[0], 1'b1);
      chk("R10 rx done", v[1], 1'b1);
      chk("R4 rx ninth", v[2], nine & b9);
      chk("R8 no frame error", v[6], 1'b0);
      reg_rd(1'b0, v); chk("R2 loopback data", v, d);
      chk("R9 idle high", txd, 1'b1);
    end

    // R6 full duplex
    loop = 1'b0;
    reg_wr(1'b1, 8'h00);
    reg_wr(1'b0, 8'h6B);
    fork
      cap(10, b);
      send_rx(8'h3C, 1'b0, 1'b0, 1'b1);
    join
    chk("R6 tx frame during rx", b, {3'b111, 8'h6B, 1'b0});
    reg_rd(1'b0, v); chk("R6 rx data during tx", v, 8'h3C);
    reg_rd(1'b1, v); chk("R6 R4 ctrl after duplex", v, 8'h03);

    // R8 framing error
    reg_wr(1'b1, 8'h00);
    send_rx(8'h96, 1'b0, 1'b0, 1'b0);
    reg_rd(1'b1, v); chk("R8 frame error set", v[6], 1'b1);
    reg_rd(1'b0, v); chk("R8 byte kept", v, 8'h96);

    // R10 selective clear, bit 2 not writable
    reg_wr(1'b1, 8'h06);
    reg_rd(1'b1, v); chk("R10 write-zero clears", v, 8'h02);

    // R7 short start pulse
    reg_wr(1'b1, 8'h00);
    drv = 1'b0; repeat (16) @(negedge clk);
    drv = 1'b1; repeat (700) @(negedge clk);
    reg_rd(1'b1, v); chk("R7 glitch rejected", v, 8'h00);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    reg_rd(1'b0, v); chk("R7 recovery data", v, 8'h5A);

    // R9 write while busy
    reg_wr(1'b1, 8'h00);
    reg_wr(1'b0, 8'hA5);
    fork
      cap(10, b);
      begin repeat (100) @(negedge clk); reg_wr(1'b0, 8'h00); end
    join
    chk("R9 busy write ignored", b, {3'b111, 8'hA5, 1'b0});
    repeat (200) @(negedge clk);
    chk("R9 idle high after frame", txd, 1'b1);
    reg_rd(1'b1, v); chk("R9 single done", v[0], 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule